// File: doc/BRIEF.md
# Serial Receive Buffer with Fill Trigger and Idle Timeout

This block sits between the receive deserializer of a serial port and the register interface a host reads. Received characters enter on a one-cycle push strobe and are held in a 16-entry circular byte store. The host takes them out with a pop strobe. The oldest byte is always presented on the read-data output while the store is not empty. The current fill level is brought out as a separate output so that a register decoder can return it.

A data-ready flag tells the host that a batch is waiting. It rises when a push brings the fill level up to a threshold picked by a 2-bit code. It can also rise when a timer sees 15 character-time ticks go by after a push that left the level short of that threshold. It falls only when a pop leaves the level below the threshold, or when the store is cleared. A level interrupt follows the flag's rising events while a receive-interrupt enable is high. It drops in the same cycle that enable goes low. A control write carries the new threshold code and can also empty the whole store.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset the level is 0, the data-ready flag and the interrupt are low, read-valid is low, and the threshold is one byte.
- R2: Bytes leave in the order they arrived. Up to 16 are held, and the read and write positions wrap from 15 to 0 without losing order.
- R3: A push while 16 bytes are held (with no pop in that cycle) is dropped. The level stays 16 and the stored bytes are unchanged.
- R4: A pop while empty changes nothing. While empty, read-valid is low and read data is 0x00.
- R5: The threshold code is taken from control bits 7:6 on a control write: code 0 selects 1 byte, code 1 selects 4, code 2 selects 8 and code 3 selects 14. The flag is high in the cycle after a push that brings the level to the threshold or above.
- R6: A pop that leaves the level below the threshold clears the flag in the next cycle. A pop that leaves it at or above the threshold keeps the flag.
- R7: A push and a pop in the same cycle, when the store is neither full nor empty, leave the level unchanged and keep the byte order.
- R8: A push that leaves the level below the threshold restarts an idle count. The 15th character tick after it with no further push sets the flag. A push that reaches the threshold cancels the count.
- R9: The idle count is held at zero while the store is empty, so ticks seen then have no effect on the flag.
- R10: A control write with bit 1 set empties the store: the level becomes 0, the flag and interrupt clear, and any push in that cycle is dropped.
- R11: An event that sets the flag also raises the interrupt when the enable is high. The interrupt falls at once when the enable goes low, the flag is left unchanged, and the interrupt stays low until a new event. An event seen while the enable is low leaves the interrupt low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Received byte strobe |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Host read strobe, takes the oldest byte |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bits 7:6 threshold code, bit 1 clear store |
| rx_ie_i | input | 1 | Receive interrupt enable |
| char_tick_i | input | 1 | One pulse per character time |
| rd_data_o | output | 8 | Oldest byte, or 0x00 when empty |
| rd_valid_o | output | 1 | Store not empty |
| level_o | output | 5 | Number of bytes held |
| data_ready_o | output | 1 | Data-ready flag |
| rx_irq_o | output | 1 | Level receive interrupt |

## Verification
The assertions assume that every strobe input is a clean single-bit level that is sampled at the rising edge. They also assume that the character tick comes as single-cycle pulses spaced well apart compared with the threshold counts. Pops and pushes may arrive in the same cycle. Pops on an empty store and pushes on a full one are legal and must be absorbed. The stimulus changes inputs one time unit after each rising edge and drives ticks as isolated one-cycle pulses with an idle cycle between them. It applies clears only through the control write, so every assertion sees inputs that meet these assumptions.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int BYTE_W     = 8;
  localparam int STORE_SIZE = 16;
  localparam int IDLE_TICKS = 15;
  localparam int CODE_W     = 2;
  localparam int CLR_BIT    = 1;
  localparam int CODE_LSB   = 6;

  // threshold in bytes selected by the 2-bit code
  function automatic int unsigned trig_of(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // circular index advance
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned size);
    return (idx == size - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rx_ring.sv
module rx_ring
  import serial_rx_pkg::*;
#(
  parameter int DW    = BYTE_W,
  parameter int DEPTH = STORE_SIZE,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_next_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] count_q;
  logic          full;

  assign full      = (count_q == CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign push_ok_o = push_i & ~full & ~clr_i;
  assign pop_ok_o  = pop_i & ~empty_o & ~clr_i;

  always_comb begin
    if (clr_i) count_next_o = '0;
    else       count_next_o = count_q + CW'(push_ok_o) - CW'(pop_ok_o);
  end

  always_ff @(posedge clk) begin
    if (push_ok_o) mem[wr_idx] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok_o) wr_idx <= AW'(wrap_inc(int'(wr_idx), DEPTH));
      if (pop_ok_o)  rd_idx <= AW'(wrap_inc(int'(rd_idx), DEPTH));
      count_q <= count_next_o;
    end
  end

  assign rd_data_o = empty_o ? '0 : mem[rd_idx];
  assign count_o   = count_q;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i && !clr_i) |=> (count_q == CW'(DEPTH)) && $stable(wr_idx));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> empty_o && $stable(rd_idx));
  // R7
  both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full && !empty_o && !clr_i) |=> $stable(count_q));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import serial_rx_pkg::*;
#(
  parameter int LIMIT = IDLE_TICKS,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic restart_i,
  input  logic cancel_i,
  input  logic empty_next_i,
  output logic expire_o
);
  logic          armed;
  logic [TW-1:0] tcnt;
  logic          hold;

  assign hold     = clr_i | empty_next_i | restart_i | cancel_i;
  assign expire_o = armed & tick_i & ~hold & (tcnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tcnt  <= '0;
    end else if (clr_i || empty_next_i) begin
      armed <= 1'b0;
      tcnt  <= '0;
    end else if (restart_i) begin
      armed <= 1'b1;
      tcnt  <= '0;
    end else if (cancel_i || expire_o) begin
      armed <= 1'b0;
      tcnt  <= '0;
    end else if (armed && tick_i) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // R8
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !expire_o);
  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_next_i |=> (tcnt == '0) && !armed);
endmodule

// File: rtl/rx_ready_ctrl.sv
module rx_ready_ctrl
  import serial_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_ok_i,
  input  logic          pop_ok_i,
  input  logic [CW-1:0] count_next_i,
  input  logic [7:0]    trig_i,
  input  logic          expire_i,
  input  logic          rx_ie_i,
  output logic          hit_o,
  output logic          short_o,
  output logic          data_ready_o,
  output logic          rx_irq_o
);
  logic at_trig, set_ev, drop_ev, ready_q, irq_q;

  assign at_trig = int'(count_next_i) >= int'(trig_i);
  assign hit_o   = push_ok_i & at_trig;
  assign short_o = push_ok_i & ~at_trig;
  assign set_ev  = hit_o | expire_i;
  assign drop_ev = pop_ok_i & ~at_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (clr_i) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (set_ev) begin
      ready_q <= 1'b1;
      irq_q   <= rx_ie_i;
    end else begin
      if (drop_ev) ready_q <= 1'b0;
      if (drop_ev || !rx_ie_i) irq_q <= 1'b0;
    end
  end

  assign data_ready_o = ready_q;
  assign rx_irq_o     = irq_q & rx_ie_i;

  // R5
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !clr_i) |=> data_ready_o);
  // R8
  timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !clr_i) |=> data_ready_o);
  // R10
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !data_ready_o && !irq_q);
  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> data_ready_o);
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import serial_rx_pkg::*;
#(
  parameter int DW    = BYTE_W,
  parameter int DEPTH = STORE_SIZE,
  parameter int IDLE  = IDLE_TICKS,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          ctrl_wr_i,
  input  logic [7:0]    ctrl_wdata_i,
  input  logic          rx_ie_i,
  input  logic          char_tick_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic [CW-1:0] level_o,
  output logic          data_ready_o,
  output logic          rx_irq_o
);
  logic [CODE_W-1:0] code_q;
  logic [7:0]        trig;
  logic              store_clr;
  logic [CW-1:0]     count, count_next;
  logic              push_ok, pop_ok, empty, hit, short_push, expire;

  assign store_clr = ctrl_wr_i & ctrl_wdata_i[CLR_BIT];
  assign trig      = 8'(trig_of(code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (ctrl_wr_i) code_q <= ctrl_wdata_i[CODE_LSB +: CODE_W];
  end

  rx_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr_i(store_clr),
    .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
    .rd_data_o(rd_data_o), .count_o(count), .count_next_o(count_next),
    .push_ok_o(push_ok), .pop_ok_o(pop_ok), .empty_o(empty)
  );

  rx_ready_ctrl #(.CW(CW)) u_ready (
    .clk(clk), .rst_n(rst_n), .clr_i(store_clr),
    .push_ok_i(push_ok), .pop_ok_i(pop_ok), .count_next_i(count_next),
    .trig_i(trig), .expire_i(expire), .rx_ie_i(rx_ie_i),
    .hit_o(hit), .short_o(short_push),
    .data_ready_o(data_ready_o), .rx_irq_o(rx_irq_o)
  );

  rx_idle_timer #(.LIMIT(IDLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(store_clr), .tick_i(char_tick_i),
    .restart_i(short_push), .cancel_i(hit),
    .empty_next_i(count_next == '0), .expire_o(expire)
  );

  assign rd_valid_o = ~empty;
  assign level_o    = count;

  // R1
  valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == (level_o != '0));
endmodule

// File: tb/serial_rx_buffer_tb.sv
module serial_rx_buffer_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       push = 0, pop = 0, cwr = 0, ie = 0, tick = 0;
  logic [7:0] pdata = 0, cdata = 0;
  logic [7:0] rdata;
  logic       rvalid, ready, irq;
  logic [4:0] level;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_rx_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata), .pop_i(pop),
    .ctrl_wr_i(cwr), .ctrl_wdata_i(cdata), .rx_ie_i(ie), .char_tick_i(tick),
    .rd_data_o(rdata), .rd_valid_o(rvalid), .level_o(level),
    .data_ready_o(ready), .rx_irq_o(irq)
  );

  // {push, data, pop, expected level, expected head byte}; threshold 1
  localparam logic [22:0] VEC [12] = '{
    {1'b1, 8'hA1, 1'b0, 5'd1, 8'hA1},
    {1'b1, 8'hB2, 1'b0, 5'd2, 8'hA1},
    {1'b0, 8'h00, 1'b1, 5'd1, 8'hB2},
    {1'b1, 8'hC3, 1'b1, 5'd1, 8'hC3},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00},
    {1'b1, 8'h11, 1'b0, 5'd1, 8'h11},
    {1'b1, 8'h22, 1'b0, 5'd2, 8'h11},
    {1'b1, 8'h33, 1'b1, 5'd2, 8'h22},
    {1'b0, 8'h00, 1'b1, 5'd1, 8'h33},
    {1'b0, 8'h00, 1'b1, 5'd0, 8'h00},
    {1'b0, 8'h00, 1'b0, 5'd0, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_push(input logic [7:0] d);
    push = 1; pdata = d; step(); push = 0;
  endtask

  task automatic do_pop();
    pop = 1; step(); pop = 0;
  endtask

  task automatic ctrl(input logic [7:0] d);
    cwr = 1; cdata = d; step(); cwr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0; step();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    check("R1 level", level, 0);
    check("R1 ready", ready, 0);
    check("R1 irq", irq, 0);
    check("R1 valid", rvalid, 0);

    // table walk: R2 order, R4 empty pop, R7 push+pop, R5/R6 threshold 1
    for (int v = 0; v < 12; v++) begin
      push = VEC[v][22]; pdata = VEC[v][21:14]; pop = VEC[v][13];
      step();
      push = 0; pop = 0;
      check("R7 table level", level, int'(VEC[v][12:8]));
      check("R2 table head", rdata, int'(VEC[v][7:0]));
      check("R6 table ready", ready, int'(VEC[v][12:8] != 0));
    end
    check("R4 empty data", rdata, 8'h00);
    check("R4 empty valid", rvalid, 0);

    // R2 R3: fill from a wrapped position, overflow dropped
    for (int i = 0; i < 16; i++) do_push(8'(8'h30 + i));
    check("R3 full level", level, 16);
    do_push(8'hEE);
    check("R3 drop level", level, 16);
    for (int i = 0; i < 16; i++) begin
      check("R2 order", rdata, 8'h30 + i);
      do_pop();
      check("R2 level", level, 15 - i);
    end

    // R5 threshold 4 with interrupt, R6 drop, R11 raise
    ie = 1;
    ctrl(8'h42);
    for (int i = 0; i < 3; i++) do_push(8'(i));
    check("R5 below 4", ready, 0);
    do_push(8'h03);
    check("R5 at 4", ready, 1);
    check("R11 irq up", irq, 1);
    do_push(8'h04);
    do_pop();
    check("R6 kept at 4", ready, 1);
    do_pop();
    check("R6 below 4", ready, 0);
    check("R6 irq down", irq, 0);
    // R8 cancelled timer stays silent
    ticks(20);
    check("R8 cancel", ready, 0);

    // R5 threshold 8 and 14
    ctrl(8'h82);
    for (int i = 0; i < 7; i++) do_push(8'(i));
    check("R5 below 8", ready, 0);
    do_push(8'h07);
    check("R5 at 8", ready, 1);
    ctrl(8'hC2);
    for (int i = 0; i < 13; i++) do_push(8'(i));
    check("R5 below 14", ready, 0);
    do_push(8'h0D);
    check("R5 at 14", ready, 1);

    // R8 idle timeout, 15 ticks
    ctrl(8'hC2);
    do_push(8'h55);
    ticks(14);
    check("R8 14 ticks", ready, 0);
    ticks(1);
    check("R8 15 ticks", ready, 1);
    check("R11 timeout irq", irq, 1);
    // R8 restart by another push
    ctrl(8'hC2);
    do_push(8'h56);
    ticks(10);
    do_push(8'h57);
    ticks(14);
    check("R8 restart", ready, 0);
    ticks(1);
    check("R8 restart expire", ready, 1);

    // R9 empty holds the timer
    ctrl(8'hC2);
    do_push(8'h60);
    do_pop();
    ticks(20);
    check("R9 empty idle", ready, 0);
    do_push(8'h61);
    ticks(14);
    check("R9 fresh count", ready, 0);
    ticks(1);
    check("R9 expire", ready, 1);

    // R11 enable drop
    ie = 0;
    #1;
    check("R11 drop at once", irq, 0);
    check("R11 flag kept", ready, 1);
    step();
    ie = 1;
    #1;
    check("R11 stays low", irq, 0);
    step();
    check("R11 stays low later", irq, 0);
    ie = 0;
    ctrl(8'h42);
    for (int i = 0; i < 4; i++) do_push(8'(i));
    check("R11 event disabled flag", ready, 1);
    check("R11 event disabled irq", irq, 0);

    // R10 clear, push in same cycle dropped, threshold back to 1
    ie = 1;
    cwr = 1; cdata = 8'h02; push = 1; pdata = 8'h99;
    step();
    cwr = 0; push = 0;
    check("R10 level", level, 0);
    check("R10 ready", ready, 0);
    check("R10 irq", irq, 0);
    check("R10 valid", rvalid, 0);
    do_push(8'h77);
    check("R10 code 0 threshold", ready, 1);
    check("R10 head", rdata, 8'h77);

    finish_run();
  end
endmodule